// File: doc/BRIEF.md
# Configurable Memory-Mapped I/O Port Bank

This block holds a set of 8-bit bidirectional I/O ports behind a small register bus. Each port owns three registers: a configuration register, an output data register and a read-only register that returns the synchronized pad levels. For every pin, its configuration bit and its data bit together select one of four pad modes. The block turns these modes into per-pin output-enable, output-value and pull-up-enable signals for a pad model.

One port, the control port, takes over several of its pins and bits for fixed duties. Pin 6 is an input only. Pin 7 always carries a clock output. Pin 1 can be handed to a watchdog output by an option input. Data bits 7 and 6 of this port do not drive pins. Writing a 1 to either of them raises a one-cycle halt or idle request. Configuration bit 6 selects the alternate phase of a serial shift clock. Another port, the narrow port, has only six bonded pads. Its missing pads read back as a fixed constant and are never driven.

A register address is `{port index, register select}`. Writes are registered on the clock edge. Reads are combinational.

Top module: `gpio_bank`

## Requirements
- R1: After reset all configuration and data registers read 0, every pin other than the control port's clock pin has output-enable 0 and pull-up 0, and halt_req and idle_req are low.
- R2: For a normal pin, {config bit, data bit} selects the mode: 00 gives output-enable 0 and pull-up 0; 01 gives output-enable 0 and pull-up 1; 10 drives output value 0; 11 drives output value 1. A pin never has output-enable and pull-up both set. The output value is 0 whenever output-enable is 0.
- R3: bus_addr[ADDR_W-1:2] picks the port and bus_addr[1:0] picks the register: 0 configuration, 1 data, 2 pin input, 3 unused. A write to select 3 or to the pin input register changes nothing. A read of select 3 returns 0. A write takes effect on the clock edge where bus_we is high.
- R4: The pin input register returns pad_in through a two-stage synchronizer. A pad change made between two clock edges is visible on bus_rdata after the second following rising edge, and not after the first.
- R5: A write to the control port's data register with bit 7 set makes halt_req high for exactly the one cycle after the write edge.
- R6: A write to the control port's data register with bit 6 set makes idle_req high for exactly the one cycle after the write edge. The request is independent of bit 7.
- R7: A read of the control port's data register returns 0 in bits 7 and 6. A read of its configuration register returns 0 in bit 7. Configuration bit 6 drives sk_alt_phase.
- R8: Pin 6 of the control port always has output-enable 0, output value 0 and pull-up 0, whatever its register bits hold.
- R9: Pin 7 of the control port always has output-enable 1 and output value equal to clk_out_src.
- R10: When wdog_en is 1, pin 1 of the control port has output-enable equal to the inverse of wdog_out, output value 0 and pull-up equal to wdog_out, and its register bits have no effect. When wdog_en is 0, the pin follows R2.
- R11: On the narrow port, pin input bits at or above NARROW_BONDED read as the matching bits of UNBONDED_FILL (default 8'hC0). Those pins always have output-enable, output value and pull-up at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address {port, select} |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Combinational read data |
| pad_in | input | NUM_PORTS*PORT_W | Pad input levels, port p at bits [p*PORT_W +: PORT_W] |
| pad_oe | output | NUM_PORTS*PORT_W | Per-pin output enable |
| pad_out | output | NUM_PORTS*PORT_W | Per-pin output value |
| pad_pu | output | NUM_PORTS*PORT_W | Per-pin weak pull-up enable |
| wdog_en | input | 1 | Hands control-port pin 1 to the watchdog output |
| wdog_out | input | 1 | Watchdog output level |
| clk_out_src | input | 1 | Level driven on control-port pin 7 |
| halt_req | output | 1 | One-cycle halt request |
| idle_req | output | 1 | One-cycle idle request |
| sk_alt_phase | output | 1 | Alternate serial clock phase select |

## Verification
On every cycle, the assertions check the fixed pin duties of the control port: the input-only pin, the clock pin and the watchdog takeover. They also check that drive and pull-up are exclusive on every pin, that each halt or idle pulse is caused by a matching write the cycle before and that such a write always produces one, and that the masked and unused read locations read back zeros. Only the bench scenarios can show the full mode table for chosen register values, the two-edge latency of the pin synchronizer, the fill constant on the unbonded pads, and that register contents survive writes to unused selects.

// File: rtl/gpio_bank_pkg.sv
// Shared encodings for the I/O port bank.
// Assumes ports are at least 8 bits wide so the fixed control bit positions exist.
package gpio_bank_pkg;

    // Pad mode chosen by {config bit, data bit}.
    typedef enum logic [1:0] {
        PIN_HIZ      = 2'b00,
        PIN_WEAK_PU  = 2'b01,
        PIN_DRIVE_LO = 2'b10,
        PIN_DRIVE_HI = 2'b11
    } pin_mode_e;

    // Register select, the low address bits.
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_DATA = 2'd1,
        REG_PINS = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int SEL_W       = 2;
    localparam int HALT_BIT    = 7;
    localparam int IDLE_BIT    = 6;
    localparam int SKPH_BIT    = 6;
    localparam int CFG_SPARE   = 7;
    localparam int IN_ONLY_PIN = 6;
    localparam int CLKOUT_PIN  = 7;
    localparam int WDOG_PIN    = 1;

endpackage

// File: rtl/gpio_port_regs.sv
// Configuration and data register pair of one port.
// Assumes the bus presents one write per cycle. Pin input registers are not stored here.
module gpio_port_regs #(
    parameter int PORT_W  = 8,
    parameter int IDX_W   = 2,
    parameter int PORT_ID = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          wr_port,
    input  gpio_bank_pkg::reg_sel_e   wr_sel,
    input  logic                      wr_en,
    input  logic [PORT_W-1:0]         wr_data,
    output logic [PORT_W-1:0]         cfg_q,
    output logic [PORT_W-1:0]         data_q
);
    import gpio_bank_pkg::*;

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(PORT_ID);

    logic hit;
    assign hit = wr_en && (wr_port == MY_IDX);

    // Configuration register: cleared on reset, loaded by a write to select 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (hit && wr_sel == REG_CFG)
            cfg_q <= wr_data;
    end

    // Data register: cleared on reset, loaded by a write to select 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (hit && wr_sel == REG_DATA)
            data_q <= wr_data;
    end

endmodule

// File: rtl/gpio_pin_mode.sv
// Per-pin decode of {config, data} into pad controls for one port.
// Purely combinational. Fixed-duty pins are handled later at the top level.
module gpio_pin_mode #(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] cfg,
    input  logic [PORT_W-1:0] data,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] out,
    output logic [PORT_W-1:0] pu
);
    import gpio_bank_pkg::*;

    // Map one mode to {output enable, output value, pull-up}.
    function automatic logic [2:0] mode_to_pad(input pin_mode_e m);
        case (m)
            PIN_HIZ:      return 3'b000;
            PIN_WEAK_PU:  return 3'b001;
            PIN_DRIVE_LO: return 3'b100;
            PIN_DRIVE_HI: return 3'b110;
            default:      return 3'b000;
        endcase
    endfunction

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'({cfg[i], data[i]});
        assign {oe[i], out[i], pu[i]} = mode_to_pad(mode);
    end

endmodule

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for pad levels.
// Assumes the pad inputs need no glitch filtering beyond resampling.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // First stage: capture the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage1 <= '0;
        else
            stage1 <= async_in;
    end

    // Second stage: resample to settle a metastable first stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_out <= '0;
        else
            sync_out <= stage1;
    end

endmodule

// File: rtl/gpio_power_ctrl.sv
// Turns writes to the control port's request bits into one-cycle pulses.
// Assumes the strobe is high for one cycle per bus write.
module gpio_power_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_strobe,
    input  logic halt_bit,
    input  logic idle_bit,
    output logic halt_req,
    output logic idle_req
);
    // Register the requests so that each lasts exactly one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req <= 1'b0;
            idle_req <= 1'b0;
        end else begin
            halt_req <= wr_strobe && halt_bit;
            idle_req <= wr_strobe && idle_bit;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Bank of memory-mapped I/O ports with four-mode pins.
// Assumes: PORT_W >= 8, ADDR_W >= SEL_W + clog2(NUM_PORTS), and
// SPECIAL_PORT differs from NARROW_PORT. Writes are registered; reads are combinational.
module gpio_bank #(
    parameter int              NUM_PORTS     = 3,
    parameter int              PORT_W        = 8,
    parameter int              ADDR_W        = 4,
    parameter int              SPECIAL_PORT  = 1,
    parameter int              NARROW_PORT   = 0,
    parameter int              NARROW_BONDED = 6,
    parameter logic [PORT_W-1:0] UNBONDED_FILL = 8'hC0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [PORT_W-1:0]             bus_wdata,
    output logic [PORT_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_pu,
    input  logic                          wdog_en,
    input  logic                          wdog_out,
    input  logic                          clk_out_src,
    output logic                          halt_req,
    output logic                          idle_req,
    output logic                          sk_alt_phase
);
    import gpio_bank_pkg::*;

    localparam int PINS     = NUM_PORTS * PORT_W;
    localparam int IDX_W    = ADDR_W - SEL_W;
    localparam int SP_BASE  = SPECIAL_PORT * PORT_W;
    localparam int NB_BASE  = NARROW_PORT * PORT_W;
    localparam logic [IDX_W-1:0]  SP_IDX = IDX_W'(SPECIAL_PORT);
    localparam logic [PORT_W-1:0] SP_DATA_MASK =
        ~((PORT_W'(1) << HALT_BIT) | (PORT_W'(1) << IDLE_BIT));
    localparam logic [PORT_W-1:0] SP_CFG_MASK  = ~(PORT_W'(1) << CFG_SPARE);
    localparam logic [PORT_W-1:0] BONDED_MASK  = (PORT_W'(1) << NARROW_BONDED) - PORT_W'(1);

    logic [IDX_W-1:0] acc_port;
    reg_sel_e         acc_sel;
    assign acc_port = bus_addr[ADDR_W-1:SEL_W];
    assign acc_sel  = reg_sel_e'(bus_addr[SEL_W-1:0]);

    logic [PORT_W-1:0] cfg_q   [NUM_PORTS];
    logic [PORT_W-1:0] data_q  [NUM_PORTS];
    logic [PORT_W-1:0] cfg_rd  [NUM_PORTS];
    logic [PORT_W-1:0] data_rd [NUM_PORTS];
    logic [PORT_W-1:0] pins_rd [NUM_PORTS];
    logic [PINS-1:0]   dec_oe, dec_out, dec_pu;
    logic [PINS-1:0]   pad_sync;

    gpio_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port_regs #(
            .PORT_W  (PORT_W),
            .IDX_W   (IDX_W),
            .PORT_ID (p)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_port (acc_port),
            .wr_sel  (acc_sel),
            .wr_en   (bus_we),
            .wr_data (bus_wdata),
            .cfg_q   (cfg_q[p]),
            .data_q  (data_q[p])
        );

        gpio_pin_mode #(.PORT_W(PORT_W)) u_mode (
            .cfg  (cfg_q[p]),
            .data (data_q[p]),
            .oe   (dec_oe [p*PORT_W +: PORT_W]),
            .out  (dec_out[p*PORT_W +: PORT_W]),
            .pu   (dec_pu [p*PORT_W +: PORT_W])
        );

        // Readback views: mask the request and spare bits on the control port,
        // and substitute the fill constant on the narrow port's missing pads.
        if (p == SPECIAL_PORT) begin : g_special_rd
            assign cfg_rd[p]  = cfg_q[p]  & SP_CFG_MASK;
            assign data_rd[p] = data_q[p] & SP_DATA_MASK;
        end else begin : g_plain_rd
            assign cfg_rd[p]  = cfg_q[p];
            assign data_rd[p] = data_q[p];
        end

        if (p == NARROW_PORT) begin : g_narrow_rd
            assign pins_rd[p] = (pad_sync[p*PORT_W +: PORT_W] & BONDED_MASK)
                              | (UNBONDED_FILL & ~BONDED_MASK);
        end else begin : g_full_rd
            assign pins_rd[p] = pad_sync[p*PORT_W +: PORT_W];
        end
    end

    // Pad control: decoded modes, then fixed-duty pin overrides.
    always_comb begin
        pad_oe  = dec_oe;
        pad_out = dec_out;
        pad_pu  = dec_pu;

        pad_oe [SP_BASE + IN_ONLY_PIN] = 1'b0;
        pad_out[SP_BASE + IN_ONLY_PIN] = 1'b0;
        pad_pu [SP_BASE + IN_ONLY_PIN] = 1'b0;

        pad_oe [SP_BASE + CLKOUT_PIN]  = 1'b1;
        pad_out[SP_BASE + CLKOUT_PIN]  = clk_out_src;
        pad_pu [SP_BASE + CLKOUT_PIN]  = 1'b0;

        if (wdog_en) begin
            pad_oe [SP_BASE + WDOG_PIN] = !wdog_out;
            pad_out[SP_BASE + WDOG_PIN] = 1'b0;
            pad_pu [SP_BASE + WDOG_PIN] = wdog_out;
        end

        for (int b = NARROW_BONDED; b < PORT_W; b++) begin
            pad_oe [NB_BASE + b] = 1'b0;
            pad_out[NB_BASE + b] = 1'b0;
            pad_pu [NB_BASE + b] = 1'b0;
        end
    end

    // Read mux: select port, then register.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (acc_port == IDX_W'(p)) begin
                case (acc_sel)
                    REG_CFG:  bus_rdata = cfg_rd[p];
                    REG_DATA: bus_rdata = data_rd[p];
                    REG_PINS: bus_rdata = pins_rd[p];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    logic sp_data_wr;
    assign sp_data_wr = bus_we && (acc_port == SP_IDX) && (acc_sel == REG_DATA);

    gpio_power_ctrl u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (sp_data_wr),
        .halt_bit  (bus_wdata[HALT_BIT]),
        .idle_bit  (bus_wdata[IDLE_BIT]),
        .halt_req  (halt_req),
        .idle_req  (idle_req)
    );

    assign sk_alt_phase = cfg_q[SPECIAL_PORT][SKPH_BIT];

endmodule

// File: rtl/gpio_bank_checker.sv
// Protocol checker for gpio_bank, attached by bind.
// Watches only ports of the bank.
module gpio_bank_checker #(
    parameter int NUM_PORTS    = 3,
    parameter int PORT_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int SPECIAL_PORT = 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [1:0]                  wdata_req,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    input logic [NUM_PORTS*PORT_W-1:0] pad_pu,
    input logic                        clk_pin_out,
    input logic                        wdog_en,
    input logic                        wdog_out,
    input logic                        clk_out_src,
    input logic                        halt_req,
    input logic                        idle_req
);
    localparam int SPB = SPECIAL_PORT * PORT_W;
    localparam logic [ADDR_W-1:0] SP_DATA_ADDR = ADDR_W'(SPECIAL_PORT * 4 + 1);

    AST_DRIVE_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0); // R2

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1:0] == 2'd3 |-> bus_rdata == '0); // R3

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(bus_we && bus_addr == SP_DATA_ADDR && wdata_req[1])); // R5

    AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SP_DATA_ADDR && wdata_req[1]) |=> halt_req); // R5

    AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> $past(bus_we && bus_addr == SP_DATA_ADDR && wdata_req[0])); // R6

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SP_DATA_ADDR && wdata_req[0]) |=> idle_req); // R6

    AST_REQ_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == SP_DATA_ADDR |-> bus_rdata[7:6] == 2'b00); // R7

    AST_INPUT_ONLY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[SPB + 6] && !pad_pu[SPB + 6]); // R8

    AST_CLOCK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[SPB + 7] && clk_pin_out == clk_out_src); // R9

    AST_WDOG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_en |-> (pad_oe[SPB + 1] == !wdog_out) && (pad_pu[SPB + 1] == wdog_out)); // R10

endmodule

bind gpio_bank gpio_bank_checker #(
    .NUM_PORTS    (NUM_PORTS),
    .PORT_W       (PORT_W),
    .ADDR_W       (ADDR_W),
    .SPECIAL_PORT (SPECIAL_PORT)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .wdata_req   (bus_wdata[7:6]),
    .bus_rdata   (bus_rdata),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu),
    .clk_pin_out (pad_out[SPECIAL_PORT*PORT_W + 7]),
    .wdog_en     (wdog_en),
    .wdog_out    (wdog_out),
    .clk_out_src (clk_out_src),
    .halt_req    (halt_req),
    .idle_req    (idle_req)
);

// File: tb/gpio_bank_test.sv
// Directed bench for gpio_bank: one task per scenario, each checks its own results.
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_oe, pad_out, pad_pu;
    logic        wdog_en = 1'b0;
    logic        wdog_out = 1'b1;
    logic        clk_out_src = 1'b0;
    logic        halt_req, idle_req, sk_alt_phase;

    int checks = 0;
    int errors = 0;

    // Address map: {port[1:0], select[1:0]}; port 1 is the control port, port 0 the narrow one.
    localparam logic [3:0] P0_CFG = 4'd0, P0_DATA = 4'd1, P0_PINS = 4'd2;
    localparam logic [3:0] P1_CFG = 4'd4, P1_DATA = 4'd5, P1_PINS = 4'd6;
    localparam logic [3:0] P2_CFG = 4'd8, P2_DATA = 4'd9, P2_PINS = 4'd10, P2_NONE = 4'd11;

    always #10 clk = ~clk;

    gpio_bank uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pad_pu       (pad_pu),
        .wdog_en      (wdog_en),
        .wdog_out     (wdog_out),
        .clk_out_src  (clk_out_src),
        .halt_req     (halt_req),
        .idle_req     (idle_req),
        .sk_alt_phase (sk_alt_phase)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        #1;
        check("R1", "oe in reset", pad_oe, 24'h008000);
        check("R1", "pu in reset", pad_pu, 24'h0);
        check("R1", "halt/idle in reset", {halt_req, idle_req}, 0);
        @(negedge clk); rst_n = 1'b1;
        bus_read(P2_CFG, v);  check("R1", "cfg2 after reset", v, 0);
        bus_read(P2_DATA, v); check("R1", "data2 after reset", v, 0);
    endtask

    task automatic t_modes;
        bus_write(P2_CFG, 8'hF0);
        bus_write(P2_DATA, 8'hCC);
        #1;
        check("R2", "oe modes", pad_oe[23:16], 8'hF0);
        check("R2", "out modes", pad_out[23:16], 8'hC0);
        check("R2", "pu modes", pad_pu[23:16], 8'h0C);
        bus_write(P2_DATA, 8'h33);
        #1;
        check("R2", "oe modes b", pad_oe[23:16], 8'hF0);
        check("R2", "out modes b", pad_out[23:16], 8'h30);
        check("R2", "pu modes b", pad_pu[23:16], 8'h03);
    endtask

    task automatic t_regmap;
        logic [7:0] v;
        bus_write(P2_NONE, 8'h5A);
        bus_write(P2_PINS, 8'hA5);
        bus_read(P2_CFG, v);  check("R3", "cfg2 kept", v, 8'hF0);
        bus_read(P2_DATA, v); check("R3", "data2 kept", v, 8'h33);
        bus_read(P2_NONE, v); check("R3", "select 3 reads zero", v, 0);
        check("R3", "pads kept", pad_out[23:16], 8'h30);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        bus_addr = P2_PINS;
        @(negedge clk); pad_in[23:16] = 8'h96;
        @(negedge clk); bus_read(P2_PINS, v);
        check("R4", "one edge later", v, 8'h00);
        @(negedge clk); bus_read(P2_PINS, v);
        check("R4", "two edges later", v, 8'h96);
    endtask

    task automatic t_requests;
        bus_write(P1_DATA, 8'h80);
        #1;
        check("R5", "halt pulse", {halt_req, idle_req}, 2'b10);
        @(negedge clk); #1;
        check("R5", "halt pulse ends", halt_req, 0);
        bus_write(P1_DATA, 8'h40);
        #1;
        check("R6", "idle pulse", {halt_req, idle_req}, 2'b01);
        @(negedge clk); #1;
        check("R6", "idle pulse ends", idle_req, 0);
        bus_write(P2_DATA, 8'hC0);
        #1;
        check("R5", "other port no request", {halt_req, idle_req}, 0);
    endtask

    task automatic t_special_regs;
        logic [7:0] v;
        bus_write(P1_CFG, 8'hFF);
        bus_write(P1_DATA, 8'hFF);
        bus_read(P1_DATA, v); check("R7", "data bits 7:6 read zero", v, 8'h3F);
        bus_read(P1_CFG, v);  check("R7", "cfg bit 7 reads zero", v, 8'h7F);
        check("R7", "alt phase set", sk_alt_phase, 1);
        bus_write(P1_CFG, 8'hBF);
        #1;
        check("R7", "alt phase clear", sk_alt_phase, 0);
        bus_write(P1_CFG, 8'hFF);
    endtask

    task automatic t_fixed_pins;
        clk_out_src = 1'b1;
        #1;
        check("R8", "input-only pin oe/pu", {pad_oe[14], pad_pu[14], pad_out[14]}, 0);
        check("R9", "clock pin high", {pad_oe[15], pad_out[15]}, 2'b11);
        check("R2", "port1 oe", pad_oe[15:8], 8'hBF);
        clk_out_src = 1'b0;
        #1;
        check("R9", "clock pin low", {pad_oe[15], pad_out[15]}, 2'b10);
        bus_write(P1_DATA, 8'h00);
        #1;
        check("R8", "input-only pin, data 0", {pad_oe[14], pad_pu[14]}, 0);
    endtask

    task automatic t_wdog;
        bus_write(P1_DATA, 8'h02);
        wdog_en = 1'b1; wdog_out = 1'b0;
        #1;
        check("R10", "wdog drives low", {pad_oe[9], pad_out[9], pad_pu[9]}, 3'b100);
        wdog_out = 1'b1;
        #1;
        check("R10", "wdog released with pull-up", {pad_oe[9], pad_out[9], pad_pu[9]}, 3'b001);
        wdog_en = 1'b0;
        #1;
        check("R10", "pin back to registers", {pad_oe[9], pad_out[9], pad_pu[9]}, 3'b110);
    endtask

    task automatic t_narrow;
        logic [7:0] v;
        bus_write(P0_CFG, 8'hFF);
        bus_write(P0_DATA, 8'hFF);
        #1;
        check("R11", "unbonded pins undriven", pad_oe[7:0], 8'h3F);
        check("R11", "unbonded pins out", pad_out[7:0], 8'h3F);
        pad_in[7:0] = 8'h00;
        repeat (2) @(negedge clk);
        bus_read(P0_PINS, v); check("R11", "fill with pads low", v, 8'hC0);
        pad_in[7:0] = 8'h15;
        repeat (2) @(negedge clk);
        bus_read(P0_PINS, v); check("R11", "fill with pads mixed", v, 8'hD5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_modes();
        t_regmap();
        t_sync();
        t_requests();
        t_special_regs();
        t_fixed_pins();
        t_wdog();
        t_narrow();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule